// File: doc/BRIEF.md
# Timer Channel Match/Capture Unit

This block is one channel of a timer subsystem. Two free-running time bases come into it. The channel holds two match slots, A and B. Each slot keeps a programmed threshold and chooses one of the two time bases to compare against. A slot fires when its chosen time base is at or beyond the threshold. It therefore still fires when the time base jumps past the exact value. On firing, the slot sets a sticky event flag and stores the time base value into its own capture register. The flag stays set until an explicit clear. While the flag is set, the slot stays quiet.

The channel also watches an asynchronous pin. The pin passes through a synchroniser, and the channel detects the edge kinds that software selects. A detected edge loads both capture registers with the current time bases. A two-bit mode decides which event flags raise the channel's service request.

Top module: `evt_chan_unit`

## Requirements
- R1: After synchronous reset, both event flags, both capture registers and the service request are 0.
- R2: A slot never fires until its threshold has been written (`wr_en_i` with `wr_sel_i` = 0 for A, 1 for B), whatever the time bases read.
- R3: An armed, unlatched slot sets its flag on the clock edge where its chosen time base is greater than or equal to its threshold (24-bit unsigned compare). This includes a time base that skips over the exact value.
- R4: `wr_tbsel_i` is stored with the threshold: 0 compares against `tb1_i`, 1 against `tb2_i`. The other time base has no effect on that slot.
- R5: A flag stays set until `clr_i` bit 0 (A) or bit 1 (B) is high for a cycle, and it is 0 after that edge. Clear beats a simultaneous fire.
- R6: While a slot's flag is set, its capture register is not reloaded by further matches.
- R7: On a fire, the slot's capture register takes the value of its chosen time base at that edge.
- R8: The pin passes through two synchroniser flops. The `edge_mode_i` values are 0 = off, 1 = rising, 2 = falling, 3 = both. An edge on the pin is acted on at the third clock edge after it is sampled.
- R9: A detected pin edge loads capture A with `tb1_i` and capture B with `tb2_i`.
- R10: When a fire and a pin edge land on the same edge, the capture register takes the fire's value.
- R11: `svc_req_o` is high when (`svc_mode_i` bit 0 and flag A) or (`svc_mode_i` bit 1 and flag B). It follows the flags and the mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb1_i | input | 24 | Time base 1 |
| tb2_i | input | 24 | Time base 2 |
| pin_i | input | 1 | Asynchronous pin input |
| wr_en_i | input | 1 | Threshold write strobe |
| wr_sel_i | input | 1 | Slot written: 0 = A, 1 = B |
| wr_data_i | input | 24 | Threshold value |
| wr_tbsel_i | input | 1 | Time base chosen by the written slot |
| edge_mode_i | input | 2 | Pin edge selection |
| svc_mode_i | input | 2 | Service request enables per flag |
| clr_i | input | 2 | Flag clear strobes, bit 0 = A, bit 1 = B |
| flag_a_o | output | 1 | Slot A event flag |
| flag_b_o | output | 1 | Slot B event flag |
| cap_a_o | output | 24 | Capture register A |
| cap_b_o | output | 24 | Capture register B |
| svc_req_o | output | 1 | Service request |

## Verification
The bench builds the block with its defaults: 24-bit time bases and a two-flop synchroniser. The time bases are driven directly rather than counted, so the bench can jump past a threshold, hit one exactly, and hold a value flat while a flag is latched. Because the two time bases carry distinct values, the bench can tell which one a slot compared against. The same distinct values also make the capture source visible when a fire and a pin edge coincide.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

    localparam int TB_W = 24;
    localparam int N_SLOT = 2;
    localparam int SYNC_N = 2;

    typedef logic [TB_W-1:0] tstamp_t;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef enum logic {
        TB_ONE = 1'b0,
        TB_TWO = 1'b1
    } tb_pick_e;

    typedef struct packed {
        tstamp_t  thresh;
        tb_pick_e pick;
        logic     armed;
    } slot_cfg_t;

    function automatic logic slot_fires(input slot_cfg_t cfg, input logic latched,
                                        input tstamp_t now);
        return cfg.armed && !latched && (now >= cfg.thresh);
    endfunction

endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det
    import evt_chan_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    output logic       edge_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             rise, fall;
    edge_mode_e       mode;

    generate
        for (genvar s = 0; s < CHAIN; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_comb begin
        mode = edge_mode_e'(mode_i);
        rise = chain_q[STAGES-1] && !chain_q[STAGES];
        fall = !chain_q[STAGES-1] && chain_q[STAGES];
        unique case (mode)
            EDGE_RISE: edge_o = rise;
            EDGE_FALL: edge_o = fall;
            EDGE_BOTH: edge_o = rise || fall;
            default:   edge_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_match_slot.sv
module evt_match_slot
    import evt_chan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_i,
    input  tstamp_t wr_data_i,
    input  logic    wr_pick_i,
    input  logic    clr_i,
    input  tstamp_t tb1_i,
    input  tstamp_t tb2_i,
    output logic    fire_o,
    output logic    flag_o,
    output tstamp_t now_o
);
    slot_cfg_t cfg_q;
    logic      flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{thresh: '0, pick: TB_ONE, armed: 1'b0};
        end else if (wr_i) begin
            cfg_q.thresh <= wr_data_i;
            cfg_q.pick   <= tb_pick_e'(wr_pick_i);
            cfg_q.armed  <= 1'b1;
        end
    end

    always_comb begin
        now_o  = (cfg_q.pick == TB_TWO) ? tb2_i : tb1_i;
        fire_o = slot_fires(cfg_q, flag_q, now_o);
    end

    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (clr_i)  flag_q <= 1'b0;
        else if (fire_o) flag_q <= 1'b1;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/evt_chan_unit.sv
module evt_chan_unit
    import evt_chan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [TB_W-1:0] tb1_i,
    input  logic [TB_W-1:0] tb2_i,
    input  logic            pin_i,
    input  logic            wr_en_i,
    input  logic            wr_sel_i,
    input  logic [TB_W-1:0] wr_data_i,
    input  logic            wr_tbsel_i,
    input  logic [1:0]      edge_mode_i,
    input  logic [1:0]      svc_mode_i,
    input  logic [1:0]      clr_i,
    output logic            flag_a_o,
    output logic            flag_b_o,
    output logic [TB_W-1:0] cap_a_o,
    output logic [TB_W-1:0] cap_b_o,
    output logic            svc_req_o
);
    logic [N_SLOT-1:0] fire, flag;
    tstamp_t           now  [N_SLOT];
    tstamp_t           cap_q[N_SLOT];
    logic              pin_edge;

    evt_edge_det #(.STAGES(SYNC_N)) u_edge (
        .clk(clk), .rst(rst), .pin_i(pin_i), .mode_i(edge_mode_i), .edge_o(pin_edge)
    );

    generate
        for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
            localparam logic SLOT_ID = 1'(i);

            evt_match_slot u_slot (
                .clk(clk), .rst(rst),
                .wr_i(wr_en_i && (wr_sel_i == SLOT_ID)),
                .wr_data_i(wr_data_i), .wr_pick_i(wr_tbsel_i),
                .clr_i(clr_i[i]), .tb1_i(tb1_i), .tb2_i(tb2_i),
                .fire_o(fire[i]), .flag_o(flag[i]), .now_o(now[i])
            );

            // slot 0 records time base 1 on a pin edge, slot 1 records time base 2
            always_ff @(posedge clk) begin
                if (rst)           cap_q[i] <= '0;
                else if (fire[i])  cap_q[i] <= now[i];
                else if (pin_edge) cap_q[i] <= (i == 0) ? tb1_i : tb2_i;
            end
        end
    endgenerate

    assign flag_a_o  = flag[0];
    assign flag_b_o  = flag[1];
    assign cap_a_o   = cap_q[0];
    assign cap_b_o   = cap_q[1];
    assign svc_req_o = |(svc_mode_i & flag);
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk
    import evt_chan_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [TB_W-1:0] tb1_i,
    input logic [TB_W-1:0] tb2_i,
    input logic            wr_en_i,
    input logic            wr_sel_i,
    input logic [1:0]      edge_mode_i,
    input logic [1:0]      svc_mode_i,
    input logic [1:0]      clr_i,
    input logic            flag_a_o,
    input logic            flag_b_o,
    input logic [TB_W-1:0] cap_a_o,
    input logic            svc_req_o
);
    logic seen_a, seen_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_a <= 1'b0;
            seen_b <= 1'b0;
        end else if (wr_en_i) begin
            if (!wr_sel_i) seen_a <= 1'b1;
            else           seen_b <= 1'b1;
        end
    end

    // R2
    unarmed_a_chk: assert property (@(posedge clk) disable iff (rst) !seen_a |-> !flag_a_o);
    // R2
    unarmed_b_chk: assert property (@(posedge clk) disable iff (rst) !seen_b |-> !flag_b_o);
    // R5
    clear_a_chk: assert property (@(posedge clk) disable iff (rst) clr_i[0] |=> !flag_a_o);
    // R5
    clear_b_chk: assert property (@(posedge clk) disable iff (rst) clr_i[1] |=> !flag_b_o);
    // R6
    hold_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_a_o && edge_mode_i == 2'b00) |=> $stable(cap_a_o));
    // R7
    cap_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_a_o) |-> (cap_a_o == $past(tb1_i) || cap_a_o == $past(tb2_i)));
    // R11
    svc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_a_o && !flag_b_o) |-> !svc_req_o);
    // R11
    svc_off_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_mode_i == 2'b00) |-> !svc_req_o);
endmodule

bind evt_chan_unit evt_chan_chk u_chk (
    .clk(clk), .rst(rst), .tb1_i(tb1_i), .tb2_i(tb2_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .edge_mode_i(edge_mode_i),
    .svc_mode_i(svc_mode_i), .clr_i(clr_i), .flag_a_o(flag_a_o),
    .flag_b_o(flag_b_o), .cap_a_o(cap_a_o), .svc_req_o(svc_req_o)
);

// File: tb/evt_chan_unit_tb.sv
module evt_chan_unit_tb;
    localparam int CLK_NS = 10;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] tb1 = '0, tb2 = '0, wr_data = '0;
    logic         pin = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, wr_tbsel = 1'b0;
    logic [1:0]   edge_mode = 2'b00, svc_mode = 2'b00, clr = 2'b00;
    logic         flag_a, flag_b, svc;
    logic [W-1:0] cap_a, cap_b;
    int           n_run = 0, n_fail = 0;
    bit           done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    evt_chan_unit u_dut (
        .clk(clk), .rst(rst), .tb1_i(tb1), .tb2_i(tb2), .pin_i(pin),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .wr_tbsel_i(wr_tbsel),
        .edge_mode_i(edge_mode), .svc_mode_i(svc_mode), .clr_i(clr),
        .flag_a_o(flag_a), .flag_b_o(flag_b), .cap_a_o(cap_a), .cap_b_o(cap_b),
        .svc_req_o(svc)
    );

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_slot(input logic sel, input logic [W-1:0] v, input logic pick);
        wr_en = 1'b1; wr_sel = sel; wr_data = v; wr_tbsel = pick;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 flag A", flag_a, 0);
        chk("R1 flag B", flag_b, 0);
        chk("R1 cap A", cap_a, 0);
        chk("R1 cap B", cap_b, 0);
        chk("R1 svc", svc, 0);
        tb1 = 500; tb2 = 500;
        tick(3);
        chk("R2 unarmed A", flag_a, 0);
        chk("R2 unarmed B", flag_b, 0);
    endtask

    task automatic t_match_ge();
        tb1 = 50; tb2 = 0;
        wr_slot(1'b0, 100, 1'b0);
        chk("R3 below", flag_a, 0);
        tb1 = 99; tick();
        chk("R3 one below", flag_a, 0);
        tb1 = 105; tick();
        chk("R3 skip past", flag_a, 1);
        chk("R7 cap value", cap_a, 105);
        chk("R11 mode off", svc, 0);
        tb1 = 110; tick();
        chk("R5 flag held", flag_a, 1);
        chk("R6 no reload", cap_a, 105);
    endtask

    task automatic t_clear();
        tb1 = 120; clr = 2'b01; tick(); clr = 2'b00;
        chk("R5 cleared", flag_a, 0);
        tick();
        chk("R5 refire", flag_a, 1);
        chk("R7 refire cap", cap_a, 120);
        clr = 2'b01; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 1000; wr_tbsel = 1'b0;
        tick();
        clr = 2'b00; wr_en = 1'b0;
        tick(2);
        chk("R3 new threshold", flag_a, 0);
        chk("R6 cap kept", cap_a, 120);
    endtask

    task automatic t_tbsel();
        tb1 = 900; tb2 = 200;
        wr_slot(1'b1, 300, 1'b1);
        tick();
        chk("R4 other base ignored", flag_b, 0);
        tb2 = 300; tick();
        chk("R4 exact on tb2", flag_b, 1);
        chk("R4 cap from tb2", cap_b, 300);
    endtask

    task automatic t_svc();
        tb2 = 0; clr = 2'b11; tick(); clr = 2'b00;
        svc_mode = 2'b11; #1;
        chk("R11 no flags", svc, 0);
        tb2 = 400; tick();
        chk("R11 flag B set", flag_b, 1);
        svc_mode = 2'b01; #1; chk("R11 A only", svc, 0);
        svc_mode = 2'b10; #1; chk("R11 B only", svc, 1);
        svc_mode = 2'b11; #1; chk("R11 either", svc, 1);
        svc_mode = 2'b00; #1; chk("R11 none", svc, 0);
    endtask

    task automatic t_edges();
        tb1 = 10; tb2 = 20; clr = 2'b10; tick(); clr = 2'b00;
        edge_mode = 2'b01; pin = 1'b1;
        tick(2);
        chk("R8 latency", cap_a, 120);
        tick();
        chk("R9 rise cap A", cap_a, 10);
        chk("R9 rise cap B", cap_b, 20);
        tb1 = 11; tb2 = 21; pin = 1'b0; tick(4);
        chk("R8 fall ignored", cap_a, 10);
        edge_mode = 2'b10; tb1 = 12; tb2 = 22; pin = 1'b1; tick(4);
        chk("R8 rise ignored", cap_b, 20);
        pin = 1'b0; tick(3);
        chk("R8 fall cap A", cap_a, 12);
        chk("R8 fall cap B", cap_b, 22);
        edge_mode = 2'b11; tb1 = 13; tb2 = 23; pin = 1'b1; tick(3);
        chk("R8 both rise", cap_a, 13);
        edge_mode = 2'b00; tb1 = 14; pin = 1'b0; tick(4);
        chk("R8 off", cap_a, 13);
    endtask

    task automatic t_prio();
        edge_mode = 2'b01;
        wr_slot(1'b0, 500, 1'b1);
        pin = 1'b1; tick(2);
        tb2 = 600; tick();
        chk("R10 flag A", flag_a, 1);
        chk("R10 match wins", cap_a, 600);
        chk("R10 cap B match", cap_b, 600);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_match_ge();
        t_clear();
        t_tbsel();
        t_svc();
        t_edges();
        t_prio();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule